// File: doc/BRIEF.md
# SDRAM Burst Trimmer

This controller-side block watches each read or write burst that the surrounding controller opens and, when asked, cuts it short so that exactly the requested number of beats reaches or leaves the user side. For a read the block places a burst stop on the command pins early enough that the CAS-latency pipeline ends on the last wanted beat. For a write it ends the burst either with a burst stop or with an interrupting READ. In the READ case it raises the data mask over the write cycles that are left.

The controller pulses `start_i` in the cycle it issues the READ or WRITE, which is cycle 0 of the burst. With that pulse it gives the burst kind, the auto-precharge flag and the CAS latency. A truncation request carries a beat count N and may arrive in cycle 0 or in any later cycle while the burst is alive. The block also drives a per-beat strobe. For reads the strobe marks the cycles when read data is valid. For writes it marks the cycles when write data is actually stored. A one-cycle error pulse reports a request that cannot be honoured.

Top module: `sdr_burst_trim`

## Requirements
- R1: While reset is low and after it is released, the command pins sit at deselect (cs_n, ras_n, cas_n, we_n all 1), and dqm_o, dvalid_o and err_o are 0.
- R2: A burst stop is driven as cs_n=0, ras_n=1, cas_n=1, we_n=0 for exactly one cycle. In every cycle with no command, all four pins are 1.
- R3: For a read burst (READ in cycle 0, beat k valid in cycle CL+k) truncated to N beats, 1 <= N < BL, the stop appears in cycle N. That is CL-1 cycles before the last wanted beat. dvalid_o is high in cycles CL to CL+N-1 only.
- R4: The CAS latency is taken from cas_lat_i at start_i and may be 2 or 3. The read strobe window and the read stop timing follow the latched value.
- R5: A write burst (beat k presented in cycle k) truncated to N beats with trunc_rd_i=0 gets a burst stop in cycle N. dvalid_o is high in cycles 0 to N-1, and the beat offered in the stop cycle is not stored.
- R6: A write burst truncated to N beats with trunc_rd_i=1 gets a READ command (cs_n=0, ras_n=1, cas_n=0, we_n=1) in cycle N. dqm_o is high from cycle N through cycle BL-1.
- R7: For a read burst, trunc_rd_i has no effect: the termination is always a burst stop.
- R8: A request with N >= BL issues no command and no error, and the burst runs its full BL beats.
- R9: If the burst was opened with auto-precharge, any request with N < BL issues no command. err_o pulses in the cycle after the request, and the burst runs in full.
- R10: A request arriving in cycle t with N <= t cannot meet the lead time. It issues no command and pulses err_o for one cycle in cycle t+1.
- R11: Once a request is accepted, later requests in the same burst are ignored. Requests made when no burst is alive are also ignored. Neither case changes a pin or raises err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst opened this cycle (cycle 0) |
| start_wr_i | input | 1 | 1 = write burst, 0 = read burst |
| start_ap_i | input | 1 | Burst opened with auto-precharge |
| cas_lat_i | input | 2 | CAS latency for this burst (2 or 3) |
| trunc_req_i | input | 1 | Truncation request |
| trunc_len_i | input | LEN_W | Number of beats to keep |
| trunc_rd_i | input | 1 | End a write with a READ instead of a burst stop |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dqm_o | output | 1 | Data mask |
| dvalid_o | output | 1 | Beat strobe toward user side |
| err_o | output | 1 | Refused request, one-cycle pulse |

## Verification
The bench targets the off-by-one hazards of the CAS-latency offset. A read stop issued at N+CL-1 instead of N would deliver extra beats, and a strobe window keyed to the wrong latency would shift by one cycle at CL=2. The write side is tested for the stop-cycle beat: a design that counts it as stored shows one extra strobe, and one that leaves the mask too short lets tail beats through after an interrupting READ. Late requests, N=0, N equal to or above BL, protected auto-precharge bursts, second requests and idle requests are all run. Each must neither fire a command nor raise a false error.

// File: rtl/sdr_trim_pkg.sv
package sdr_trim_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_BSTOP, CMD_READ} term_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t encode_cmd(term_cmd_e c);
    case (c)
      CMD_BSTOP: encode_cmd = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
      CMD_READ:  encode_cmd = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      default:   encode_cmd = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/sdr_trim_track.sv
module sdr_trim_track #(
  parameter int BL    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic             start_ap_i,
  input  logic [1:0]       cas_lat_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wr_o,
  output logic             ap_o,
  output logic [1:0]       cl_o
);
  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BL);

  logic [CNT_W-1:0] last_c;

  // last alive cycle: write ends on its final beat, read on final data beat
  always_comb begin
    if (wr_o) last_c = BL_C - 1'b1;
    else      last_c = {{(CNT_W-2){1'b0}}, cl_o} + BL_C - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      wr_o     <= 1'b0;
      ap_o     <= 1'b0;
      cl_o     <= 2'd0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_o    <= CNT_W'(1);
      wr_o     <= start_wr_i;
      ap_o     <= start_ap_i;
      cl_o     <= cas_lat_i;
    end else if (active_o) begin
      if (cnt_o >= last_c) active_o <= 1'b0;
      else                 cnt_o    <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/sdr_trim_decide.sv
module sdr_trim_decide #(
  parameter int BL    = 4,
  parameter int LEN_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic             start_ap_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_mode_i,
  output logic             pend_o,
  output logic [CNT_W-1:0] stop_at_o,
  output logic             use_rd_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BL);

  logic [CNT_W-1:0] now_c, len_c;
  logic cur_ap, cur_wr, pend_eff, consider, refuse, accept;

  assign now_c    = start_i ? '0 : cnt_i;
  assign cur_ap   = start_i ? start_ap_i : ap_i;
  assign cur_wr   = start_i ? start_wr_i : wr_i;
  assign len_c    = CNT_W'(len_i);
  assign pend_eff = pend_o & ~start_i;
  // N >= BL needs no stop; only real truncations are judged
  assign consider = req_i & (start_i | active_i) & ~pend_eff & (len_c < BL_C);
  assign refuse   = consider & (cur_ap | (len_c <= now_c));
  assign accept   = consider & ~refuse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o    <= 1'b0;
      stop_at_o <= '0;
      use_rd_o  <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      pend_o <= pend_eff | accept;
      err_o  <= refuse;
      if (accept) begin
        stop_at_o <= len_c;
        use_rd_o  <= rd_mode_i & cur_wr;
      end
    end
  end
endmodule

// File: rtl/sdr_trim_drive.sv
module sdr_trim_drive
  import sdr_trim_pkg::*;
#(
  parameter int BL    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic [1:0]       cl_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] stop_at_i,
  input  logic             use_rd_i,
  output cmd_pins_t        pins_o,
  output logic             dqm_o,
  output logic             dvalid_o
);
  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BL);

  logic             fire, old_beat;
  term_cmd_e        cmd;
  logic [CNT_W-1:0] keep_c, cl_c, mask_q;

  assign fire     = active_i & pend_i & (cnt_i == stop_at_i);
  assign cmd      = !fire ? CMD_NONE : (use_rd_i ? CMD_READ : CMD_BSTOP);
  assign pins_o   = encode_cmd(cmd);
  assign keep_c   = pend_i ? stop_at_i : BL_C;
  assign cl_c     = {{(CNT_W-2){1'b0}}, cl_i};
  assign old_beat = active_i & ~start_i;

  always_comb begin
    dvalid_o = start_i & start_wr_i;
    if (old_beat && wr_i && cnt_i < keep_c) dvalid_o = 1'b1;
    if (old_beat && !wr_i && cnt_i >= cl_c && cnt_i < cl_c + keep_c) dvalid_o = 1'b1;
  end

  // mask the write cycles left behind an interrupting read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mask_q <= '0;
    else if (fire && use_rd_i) mask_q <= BL_C - 1'b1 - stop_at_i;
    else if (mask_q != '0)     mask_q <= mask_q - 1'b1;
  end

  assign dqm_o = (fire & use_rd_i) | (mask_q != '0);
endmodule

// File: rtl/sdr_burst_trim.sv
module sdr_burst_trim
  import sdr_trim_pkg::*;
#(
  parameter int BL     = 4,
  parameter int CL_MAX = 3,
  parameter int LEN_W  = $clog2(BL) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic             start_ap_i,
  input  logic [1:0]       cas_lat_i,
  input  logic             trunc_req_i,
  input  logic [LEN_W-1:0] trunc_len_i,
  input  logic             trunc_rd_i,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             dqm_o,
  output logic             dvalid_o,
  output logic             err_o
);
  localparam int CNT_W = LEN_W + $clog2(CL_MAX + 1);

  logic             trk_active, trk_wr, trk_ap;
  logic [CNT_W-1:0] trk_cnt, stop_at;
  logic [1:0]       trk_cl;
  logic             pend, use_rd;
  cmd_pins_t        pins;

  sdr_trim_track #(.BL(BL), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .start_i, .start_wr_i, .start_ap_i, .cas_lat_i,
    .active_o(trk_active), .cnt_o(trk_cnt), .wr_o(trk_wr), .ap_o(trk_ap), .cl_o(trk_cl)
  );

  sdr_trim_decide #(.BL(BL), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_decide (
    .clk_i, .rst_ni, .start_i, .start_wr_i, .start_ap_i,
    .active_i(trk_active), .cnt_i(trk_cnt), .wr_i(trk_wr), .ap_i(trk_ap),
    .req_i(trunc_req_i), .len_i(trunc_len_i), .rd_mode_i(trunc_rd_i),
    .pend_o(pend), .stop_at_o(stop_at), .use_rd_o(use_rd), .err_o
  );

  sdr_trim_drive #(.BL(BL), .CNT_W(CNT_W)) u_drive (
    .clk_i, .rst_ni, .start_i, .start_wr_i,
    .active_i(trk_active), .cnt_i(trk_cnt), .wr_i(trk_wr), .cl_i(trk_cl),
    .pend_i(pend), .stop_at_i(stop_at), .use_rd_i(use_rd),
    .pins_o(pins), .dqm_o, .dvalid_o
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;
endmodule

// File: rtl/sdr_burst_trim_chk.sv
module sdr_burst_trim_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic trunc_req_i,
  input logic cs_n_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic dqm_o,
  input logic dvalid_o,
  input logic err_o,
  input logic trk_active,
  input logic trk_wr,
  input logic trk_ap
);
  // R10 / R9: every error answers a request one cycle earlier
  assert_err_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(trunc_req_i));

  assert_ap_uncut_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_active && trk_ap && !start_i) |-> cs_n_o);

  assert_stop_beat_dropped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !we_n_o && trk_wr && trk_active && !start_i) |-> !dvalid_o);

  assert_dqm_starts_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqm_o) |-> (!cs_n_o && ras_n_o && !cas_n_o && we_n_o));

  assert_cmd_in_burst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> (trk_active && ras_n_o));
endmodule

bind sdr_burst_trim sdr_burst_trim_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .trunc_req_i(trunc_req_i),
  .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .dqm_o(dqm_o), .dvalid_o(dvalid_o), .err_o(err_o),
  .trk_active(trk_active), .trk_wr(trk_wr), .trk_ap(trk_ap)
);

// File: tb/sdr_burst_trim_tb_top.sv
module sdr_burst_trim_tb_top;
  localparam int BL    = 4;
  localparam int LEN_W = 3;
  localparam int NC    = 12;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic start_i, start_wr_i, start_ap_i, trunc_req_i, trunc_rd_i;
  logic [1:0] cas_lat_i;
  logic [LEN_W-1:0] trunc_len_i;
  logic cs_n_o, ras_n_o, cas_n_o, we_n_o, dqm_o, dvalid_o, err_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  sdr_burst_trim #(.BL(BL), .CL_MAX(3), .LEN_W(LEN_W)) dut_i (.*);

  task automatic check(string tag, string what, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    start_i = 0; start_wr_i = 0; start_ap_i = 0; cas_lat_i = 2'd0;
    trunc_req_i = 0; trunc_len_i = '0; trunc_rd_i = 0;
  endtask

  // One burst opened in cycle 0, up to two requests, all outputs compared.
  task automatic run(string tag, bit wr, bit ap, int cl, bit r1, int t1, int n1, bit rd,
                     bit r2, int t2, int n2);
    logic [47:0] g_pins, e_pins;
    logic [NC-1:0] g_dqm, g_dv, g_er, e_dqm, e_dv, e_er;
    int last, fire, keep;
    bit pend;
    for (int c = 0; c < NC; c++) begin
      @(posedge clk_i);
      #2;
      idle_inputs();
      if (c == 0) begin
        start_i = 1; start_wr_i = wr; start_ap_i = ap; cas_lat_i = 2'(cl);
      end
      if (r1 && c == t1) begin trunc_req_i = 1; trunc_len_i = LEN_W'(n1); trunc_rd_i = rd; end
      if (r2 && c == t2) begin trunc_req_i = 1; trunc_len_i = LEN_W'(n2); trunc_rd_i = rd; end
      #8;
      g_pins[c*4 +: 4] = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
      g_dqm[c] = dqm_o; g_dv[c] = dvalid_o; g_er[c] = err_o;
    end
    #2 idle_inputs();
    g_pins[47:4*NC] = '0;
    // model
    last = wr ? BL - 1 : cl + BL - 1;
    pend = 0; fire = -1;
    e_er = '0; e_dqm = '0; e_dv = '0;
    for (int k = 0; k < 2; k++) begin
      bit en = (k == 0) ? r1 : r2;
      int t  = (k == 0) ? t1 : t2;
      int n  = (k == 0) ? n1 : n2;
      if (en && t <= last && !pend && n < BL) begin
        if (ap || n <= t) e_er[t+1] = 1'b1;
        else begin pend = 1; fire = n; end
      end
    end
    e_pins = '0;
    for (int c = 0; c < NC; c++) e_pins[c*4 +: 4] = 4'b1111;
    if (fire >= 0) e_pins[fire*4 +: 4] = (wr && rd) ? 4'b0101 : 4'b0110;
    keep = (fire >= 0) ? fire : BL;
    for (int c = 0; c < NC; c++) begin
      if (wr && c < keep) e_dv[c] = 1'b1;
      if (!wr && c >= cl && c < cl + keep) e_dv[c] = 1'b1;
      if (fire >= 0 && wr && rd && c >= fire && c < BL) e_dqm[c] = 1'b1;
    end
    check(tag, "pins", g_pins, e_pins);
    check(tag, "dqm", 48'(g_dqm), 48'(e_dqm));
    check(tag, "dvalid", 48'(g_dv), 48'(e_dv));
    check(tag, "err", 48'(g_er), 48'(e_er));
  endtask

  task automatic test_reset();
    idle_inputs();
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #5;
    check("R1", "pins in reset", 48'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 48'hF);
    #2 rst_ni = 1;
    @(posedge clk_i);
    #8;
    check("R1", "pins after reset", 48'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 48'hF);
    check("R1", "dqm/dvalid/err", 48'({dqm_o, dvalid_o, err_o}), 48'h0);
  endtask

  task automatic test_read_trunc();   // R3, R2
    run("R3_n2_cl3", 0, 0, 3, 1, 0, 2, 0, 0, 0, 0);
    run("R3_n1_same_cycle", 0, 0, 3, 1, 0, 1, 0, 0, 0, 0);
    run("R3_n3_late_ok", 0, 0, 3, 1, 2, 3, 0, 0, 0, 0);
  endtask

  task automatic test_cl2();          // R4
    run("R4_n2_cl2", 0, 0, 2, 1, 0, 2, 0, 0, 0, 0);
    run("R4_n3_cl2", 0, 0, 2, 1, 1, 3, 0, 0, 0, 0);
    run("R4_full_cl2", 0, 0, 2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_write_stop();   // R5, R2
    run("R5_n2", 1, 0, 3, 1, 0, 2, 0, 0, 0, 0);
    run("R5_n1", 1, 0, 3, 1, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic test_write_by_read(); // R6
    run("R6_n1", 1, 0, 3, 1, 0, 1, 1, 0, 0, 0);
    run("R6_n3", 1, 0, 2, 1, 1, 3, 1, 0, 0, 0);
  endtask

  task automatic test_read_mode_ignored(); // R7
    run("R7_read_rdmode", 0, 0, 3, 1, 0, 2, 1, 0, 0, 0);
  endtask

  task automatic test_no_trunc();     // R8
    run("R8_read_n4", 0, 0, 3, 1, 0, 4, 0, 0, 0, 0);
    run("R8_write_n5", 1, 0, 3, 1, 1, 5, 1, 0, 0, 0);
  endtask

  task automatic test_ap();           // R9
    run("R9_write_ap", 1, 1, 3, 1, 0, 2, 0, 0, 0, 0);
    run("R9_read_ap", 0, 1, 2, 1, 1, 3, 0, 0, 0, 0);
  endtask

  task automatic test_late();         // R10
    run("R10_t2_n2", 0, 0, 3, 1, 2, 2, 0, 0, 0, 0);
    run("R10_n0", 1, 0, 3, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_ignore();       // R11
    run("R11_second_req", 0, 0, 3, 1, 0, 3, 0, 1, 1, 1);
    run("R11_idle_req", 1, 0, 3, 1, 7, 2, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_read_trunc();
    test_cl2();
    test_write_stop();
    test_write_by_read();
    test_read_mode_ignored();
    test_no_trunc();
    test_ap();
    test_late();
    test_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule